// File: doc/BRIEF.md
# Serial PHY Power-Up Sequencer

This block brings a serial link PHY from cold to usable after a single start pulse. It drives the pad-control bits in a fixed order. First it forces the lane power-down override. It then programs the PLL reference source and the transmit reference divider, and lets the PLL out of reset. Next it waits for the PLL to report lock, polling the lock input at a slow, bounded rate.

Once lock is seen, it drops the power-down override, and only after that does it open the transmit and receive data paths. It then releases the interface logic from reset and, as the very last step, enables the bridge. The lock wait is bounded. If lock never arrives, the sequence stops with the override still on and the data paths shut, and it raises a sticky error flag.

The poll interval comes from a prescaler. Its division ratio is a parameter, so a fast simulation can shrink one millisecond to a few clocks. A system controller pulses `start_i` and then watches `done_o` or `err_o`.

Top module: `phy_bringup_seq`

## Requirements
- R1: During and after a synchronous active-high reset the outputs are: override 0, `ref_sel_o` = 2 (external), `tx_div5_o` = 1, `pll_run_o` 0, both data enables 0, `iface_rst_o` 1, `bridge_en_o` 0, and `busy_o`, `done_o`, `err_o` all 0.
- R2: A start pulse sampled while idle sets the override, clears `done_o` and `err_o`, clears `pll_run_o`, both data enables and `bridge_en_o`, sets `iface_rst_o`, and raises `busy_o`, all on that same edge.
- R3: One edge after the start edge, `ref_sel_o` is written to 0 (encodings: 0 internal CML, 1 internal CMOS, 2 external). On that same edge `tx_div5_o` is written to 0 (0 selects divide by 10, 1 selects divide by 5), while `pll_run_o` stays 0.
- R4: `pll_run_o` rises one edge after the reference selections are written, which is two edges after the start edge. At that point the override is still set.
- R5: Lock is sampled once every `TICK_DIV` cycles, starting from the edge that releases the PLL, for at most `MAX_POLLS` samples. With a successful poll p, `done_o` rises 3 + p·`TICK_DIV` edges after the PLL release edge.
- R6: If `MAX_POLLS` polls find no lock, `err_o` rises `MAX_POLLS`·`TICK_DIV` edges after the PLL release edge. The override stays set, the data enables and `bridge_en_o` stay 0, and `err_o` holds until the next start.
- R7: The override clears on the edge of the successful poll. Both data enables rise exactly one edge later, and never while the override is set.
- R8: `iface_rst_o` falls one edge after the data enables rise. `bridge_en_o` and `done_o` rise one edge after that.
- R9: A start pulse while `busy_o` is high has no effect on the sequence or its timing.
- R10: `done_o` and `err_o` are never both high, and each holds while idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, acted on only while idle |
| pll_lock_i | input | 1 | PLL lock-detect status |
| iddq_ovr_o | output | 1 | Lane power-down override |
| ref_sel_o | output | 2 | PLL reference source select |
| tx_div5_o | output | 1 | TX reference divider (1 = divide by 5) |
| pll_run_o | output | 1 | PLL out of reset |
| tx_data_en_o | output | 1 | Transmit data path enable |
| rx_data_en_o | output | 1 | Receive data path enable |
| iface_rst_o | output | 1 | Interface module reset |
| bridge_en_o | output | 1 | Bridge enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed (sticky) |
| err_o | output | 1 | Lock timeout (sticky) |

## Verification
A wrong step state shows at the ports on the very next edge, as a pad bit changing out of order. Examples are a data enable rising while the override is still set, or the PLL released before the reference field reads CML. A fault in the prescaler or the poll counter shows up later, and only as a shift in the edge at which `done_o` or `err_o` appears. The bench therefore measures that edge against the poll arithmetic for lock arriving before, exactly at and just after each poll boundary, including the final poll.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [1:0] {
        REF_CML  = 2'd0,
        REF_CMOS = 2'd1,
        REF_EXT  = 2'd2
    } ref_src_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_REL,
        ST_WAIT,
        ST_DATA,
        ST_IFACE,
        ST_BRIDGE
    } seq_state_t;

    typedef struct packed {
        logic     iddq;
        ref_src_t ref_sel;
        logic     div5;
        logic     pll_run;
        logic     tx_en;
        logic     rx_en;
        logic     iface_rst;
        logic     bridge_en;
    } pad_ctrl_t;

    localparam pad_ctrl_t PAD_RESET = '{
        iddq:      1'b0,
        ref_sel:   REF_EXT,
        div5:      1'b1,
        pll_run:   1'b0,
        tx_en:     1'b0,
        rx_en:     1'b0,
        iface_rst: 1'b1,
        bridge_en: 1'b0
    };

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    import phy_seq_pkg::*;

    localparam int unsigned W = cnt_width(TICK_DIV);
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/seq_poll_counter.sv
module seq_poll_counter #(
    parameter int unsigned MAX_POLLS = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    import phy_seq_pkg::*;

    localparam int unsigned W = cnt_width(MAX_POLLS + 1);
    localparam logic [W-1:0] LAST = W'(MAX_POLLS - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
    parameter int unsigned TICK_DIV  = 50000,
    parameter int unsigned MAX_POLLS = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       pll_lock_i,
    output logic       iddq_ovr_o,
    output logic [1:0] ref_sel_o,
    output logic       tx_div5_o,
    output logic       pll_run_o,
    output logic       tx_data_en_o,
    output logic       rx_data_en_o,
    output logic       iface_rst_o,
    output logic       bridge_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    import phy_seq_pkg::*;

    seq_state_t st_q;
    pad_ctrl_t  pad_q;
    logic       done_q, err_q;
    logic       tick, last_poll, in_wait;

    assign in_wait = (st_q == ST_WAIT);

    seq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (st_q == ST_REL),
        .en_i   (in_wait),
        .tick_o (tick)
    );

    seq_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (st_q == ST_REL),
        .inc_i  (tick && !pll_lock_i),
        .last_o (last_poll)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pad_q  <= PAD_RESET;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pad_q.iddq      <= 1'b1;
                        pad_q.pll_run   <= 1'b0;
                        pad_q.tx_en     <= 1'b0;
                        pad_q.rx_en     <= 1'b0;
                        pad_q.iface_rst <= 1'b1;
                        pad_q.bridge_en <= 1'b0;
                        done_q          <= 1'b0;
                        err_q           <= 1'b0;
                        st_q            <= ST_CFG;
                    end
                end
                ST_CFG: begin
                    pad_q.ref_sel <= REF_CML;
                    pad_q.div5    <= 1'b0;
                    st_q          <= ST_REL;
                end
                ST_REL: begin
                    pad_q.pll_run <= 1'b1;
                    st_q          <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (pll_lock_i) begin
                            pad_q.iddq <= 1'b0;
                            st_q       <= ST_DATA;
                        end else if (last_poll) begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    pad_q.tx_en <= 1'b1;
                    pad_q.rx_en <= 1'b1;
                    st_q        <= ST_IFACE;
                end
                ST_IFACE: begin
                    pad_q.iface_rst <= 1'b0;
                    st_q            <= ST_BRIDGE;
                end
                ST_BRIDGE: begin
                    pad_q.bridge_en <= 1'b1;
                    done_q          <= 1'b1;
                    st_q            <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign iddq_ovr_o   = pad_q.iddq;
    assign ref_sel_o    = pad_q.ref_sel;
    assign tx_div5_o    = pad_q.div5;
    assign pll_run_o    = pad_q.pll_run;
    assign tx_data_en_o = pad_q.tx_en;
    assign rx_data_en_o = pad_q.rx_en;
    assign iface_rst_o  = pad_q.iface_rst;
    assign bridge_en_o  = pad_q.bridge_en;
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = done_q;
    assign err_o        = err_q;
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       pll_lock_i,
    input logic       iddq_ovr_o,
    input logic [1:0] ref_sel_o,
    input logic       tx_div5_o,
    input logic       pll_run_o,
    input logic       tx_data_en_o,
    input logic       rx_data_en_o,
    input logic       iface_rst_o,
    input logic       bridge_en_o,
    input logic       done_o,
    input logic       err_o
);
    a_r4_release_after_cfg: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_run_o) |-> iddq_ovr_o && ref_sel_o == 2'd0 && !tx_div5_o);

    a_r7_data_after_override: assert property (@(posedge clk) disable iff (rst)
        (tx_data_en_o || rx_data_en_o) |-> !iddq_ovr_o);

    a_r7_override_drop_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $fell(iddq_ovr_o) |-> $past(pll_lock_i));

    a_r8_bridge_last: assert property (@(posedge clk) disable iff (rst)
        $rose(bridge_en_o) |-> tx_data_en_o && rx_data_en_o && !iface_rst_o);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> err_o);

    a_r6_err_safe_pads: assert property (@(posedge clk) disable iff (rst)
        err_o |-> iddq_ovr_o && !tx_data_en_o && !rx_data_en_o && !bridge_en_o);

    a_r10_done_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
endmodule

bind phy_bringup_seq phy_bringup_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .pll_lock_i   (pll_lock_i),
    .iddq_ovr_o   (iddq_ovr_o),
    .ref_sel_o    (ref_sel_o),
    .tx_div5_o    (tx_div5_o),
    .pll_run_o    (pll_run_o),
    .tx_data_en_o (tx_data_en_o),
    .rx_data_en_o (rx_data_en_o),
    .iface_rst_o  (iface_rst_o),
    .bridge_en_o  (bridge_en_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int POLLS      = 5;
    localparam int NCASE      = 8;

    // per case: lock delay (edges after start), start poke edge (-1 none), expect done
    localparam int LOCK_D [NCASE] = '{0, 5, 6, 9, 14, 21, 22, 40};
    localparam int POKE   [NCASE] = '{-1, 3, -1, 1, 7, -1, 4, -1};
    localparam bit EXP_OK [NCASE] = '{1, 1, 1, 1, 1, 1, 0, 0};

    logic       clk = 1'b0;
    logic       rst, start, lock;
    logic       iddq, div5, pll_run, tx_en, rx_en, iface_rst, bridge, busy, done, err;
    logic [1:0] ref_sel;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_bringup_seq #(.TICK_DIV(DIV), .MAX_POLLS(POLLS)) dut (
        .clk(clk), .rst(rst), .start_i(start), .pll_lock_i(lock),
        .iddq_ovr_o(iddq), .ref_sel_o(ref_sel), .tx_div5_o(div5),
        .pll_run_o(pll_run), .tx_data_en_o(tx_en), .rx_data_en_o(rx_en),
        .iface_rst_o(iface_rst), .bridge_en_o(bridge), .busy_o(busy),
        .done_o(done), .err_o(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int poll_hit(input int d);
        for (int p = 1; p <= POLLS; p++)
            if (2 + p * DIV >= d + 1) return p;
        return 0;
    endfunction

    task automatic run_case(input int d, input int poke, input bit exp_ok);
        int n, p, exp_n, iddq_off, tx_on, rel_edge;
        n = 0; iddq_off = -1; tx_on = -1; rel_edge = -1;
        @(negedge clk);
        lock  = 1'b0;
        start = 1'b1;
        @(posedge clk); #1;
        check(iddq && busy && !done && !err && !pll_run && iface_rst && !tx_en,
              "R2", {iddq, busy, done, err}, 4'b1100);
        @(negedge clk);
        start = 1'b0;
        if (d <= 0) lock = 1'b1;
        while (!(done || err) && n < 200) begin
            @(posedge clk); #1;
            n++;
            if (n == 1) begin
                check(ref_sel == 2'd0 && div5 == 1'b0 && !pll_run, "R3", {ref_sel, div5}, 0);
            end
            if (n == 2) check(pll_run && iddq, "R4", {pll_run, iddq}, 2'b11);
            check(!((tx_en || rx_en) && iddq), "R7", {tx_en, iddq}, 0);
            if (!iddq && iddq_off < 0) iddq_off = n;
            if (tx_en && rx_en && tx_on < 0) tx_on = n;
            if (!iface_rst && rel_edge < 0) rel_edge = n;
            @(negedge clk);
            if (n >= d) lock = 1'b1;
            start = (n == poke);
        end
        start = 1'b0;
        p = poll_hit(d);
        exp_n = (p > 0) ? 5 + p * DIV : 2 + POLLS * DIV;
        check(n == exp_n, (poke >= 0) ? "R9" : (p > 0 ? "R5" : "R6"), n, exp_n);
        check(done == exp_ok && err == !exp_ok, "R10", {done, err}, {exp_ok, !exp_ok});
        if (exp_ok) begin
            check(tx_on == iddq_off + 1, "R7", tx_on, iddq_off + 1);
            check(rel_edge == tx_on + 1 && bridge && n == rel_edge + 1, "R8", rel_edge, tx_on + 1);
        end else begin
            check(iddq && !tx_en && !rx_en && !bridge && iface_rst, "R6", {iddq, tx_en, bridge}, 3'b100);
        end
        repeat (6) @(negedge clk);
        check(done == exp_ok && err == !exp_ok && !busy, "R10", {done, err, busy}, {exp_ok, !exp_ok, 1'b0});
        if (!exp_ok) check(iddq && !tx_en, "R6", {iddq, tx_en}, 2'b10);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; lock = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!iddq && ref_sel == 2'd2 && div5 && !pll_run && !tx_en && !rx_en &&
              iface_rst && !bridge && !busy && !done && !err, "R1", {ref_sel, div5}, 3'b101);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(!busy && ref_sel == 2'd2, "R1", busy, 0);
        for (int i = 0; i < NCASE; i++) run_case(LOCK_D[i], POKE[i], EXP_OK[i]);
        // restart after an error clears the flag at once
        @(negedge clk); start = 1'b1; lock = 1'b1;
        @(posedge clk); #1;
        check(!err && !done && busy && iddq, "R2", err, 0);
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        check(done && !err && bridge, "R8", done, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule